// File: doc/BRIEF.md
# Eight-Octant Circle Radius Voter

This block is one processing element of a circle-detection array that already knows the circle centre. Each edge pixel is first moved so that the centre becomes the origin. The centred pair is then rotated by the element's fixed angle using signed fixed-point coefficients. The two rotated values serve directly as the radius candidates for the first and third 45-degree octants. The diagonal octants are the sum and the difference of the two values, and the lower half-plane octants are the negations of these four. Each accepted pixel therefore casts at most one vote into each of eight per-element count banks, which gives eight votes from a single rotation.

The rotated pair also leaves the element with its own valid flag, so the next element in a chain can rotate it further by its own angle. The diagonal values carry a factor of √2, so the four diagonal banks are deeper than the four axis banks. The banks are zeroed by a sweep that runs after reset and again on each clear strobe. A combinational readout port returns any count and compares it with a threshold. Matching cell indices across elements is left to logic outside this block.

Top module: `hcv_circle_voter`

## Requirements
- R1: The element rotates the offsets X = pix_x − ctr_x and Y = pix_y − ctr_y, not the raw pixel coordinates.
- R2: Two cycles after `pix_valid`, `rot_valid` is high with `rot_x` = floor((X·COS_Q + Y·SIN_Q) / 2^FRAC) and `rot_y` = floor((Y·COS_Q − X·SIN_Q) / 2^FRAC). `rot_valid` is low two cycles after a cycle without `pix_valid`.
- R3: Bank index 0..7 maps to octant values a..h. These are a = rot_x, b = rot_x + rot_y, c = rot_y, d = rot_x − rot_y, and e, f, g, h = −a, −b, −c, −d.
- R4: An octant value votes only when it is non-negative and below its bank depth. The even banks have depth DEPTH_AX. The odd banks have depth ceil(DEPTH_AX·1449/1024), which is 46 for the defaults.
- R5: Each voting octant value adds one to the cell whose address equals that value, in that octant's bank, one cycle after `rot_valid`.
- R6: A count saturates at 2^CNT_W − 1 and does not wrap.
- R7: Reset and each `clr` pulse start a sweep. During the sweep `busy` is high for exactly the odd-bank depth in cycles, and afterwards every cell reads zero.
- R8: A vote whose write cycle falls while `busy` is high is discarded.
- R9: `rd_count` is the count at `rd_addr` in bank `rd_bank`, and reads zero when `rd_addr` lies beyond that bank's depth. `rd_hit` is high exactly when `rd_count` ≥ `thr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts a clearing sweep |
| clr | input | 1 | Clear strobe; restarts the sweep |
| ctr_x | input | PIX_W | Signed centre x |
| ctr_y | input | PIX_W | Signed centre y |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_x | input | PIX_W | Signed pixel x |
| pix_y | input | PIX_W | Signed pixel y |
| rot_valid | output | 1 | Rotated pair valid |
| rot_x | output | PIX_W+COEF_W+2−FRAC | Rotated first value (octant a) |
| rot_y | output | PIX_W+COEF_W+2−FRAC | Rotated second value (octant c) |
| busy | output | 1 | Clearing sweep in progress |
| thr | input | CNT_W | Vote threshold for rd_hit |
| rd_bank | input | 3 | Bank index, 0..7 = a..h |
| rd_addr | input | clog2(diagonal depth) | Cell address to read |
| rd_count | output | CNT_W | Count at the selected cell |
| rd_hit | output | 1 | Count reaches threshold |

## Verification
The assertions check the two-cycle latency of the rotated pair on every cycle. They also check that a cell at full count holds its value when it is hit again, and that a clear write and a vote never share a cycle. They check that the sweep ends only at its last address. They also check the fold: opposite octants can both vote only when the shared value is zero. The exact rotated values, the address each vote lands on, the depth cut-offs, the sweep length and the zeroed contents can only be shown by the bench. It does this with directed and seeded random pixels and then compares every cell of every bank against its own model.

// File: rtl/hcv_pkg.sv
package hcv_pkg;
   localparam int NOCT = 8;

   typedef enum logic [2:0] {
      OCT_A, OCT_B, OCT_C, OCT_D, OCT_E, OCT_F, OCT_G, OCT_H
   } octant_e;

   // odd octants sit on the diagonals and carry the sqrt(2) factor
   function automatic bit is_diag(input int k);
      return (k % 2) == 1;
   endfunction

   // sqrt(2) ~ 1449/1024, rounded up
   function automatic int diag_depth(input int n);
      return (n * 1449 + 1023) / 1024;
   endfunction
endpackage

// File: rtl/hcv_offset_rotor.sv
module hcv_offset_rotor #(
   parameter int PIX_W  = 10,
   parameter int COEF_W = 14,
   parameter int FRAC   = 12,
   parameter int COS_Q  = 3784,
   parameter int SIN_Q  = 1567,
   localparam int DW    = PIX_W + 1,
   localparam int SW    = DW + COEF_W + 1,
   localparam int RW    = SW - FRAC
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [PIX_W-1:0] ctr_x,
   input  logic signed [PIX_W-1:0] ctr_y,
   input  logic                    pix_valid,
   input  logic signed [PIX_W-1:0] pix_x,
   input  logic signed [PIX_W-1:0] pix_y,
   output logic                    rot_valid,
   output logic signed [RW-1:0]    rot_x,
   output logic signed [RW-1:0]    rot_y
);
   logic                 off_valid;
   logic signed [DW-1:0] off_x, off_y;
   logic signed [SW-1:0] ext_x, ext_y, acc_x, acc_y;

   // stage 1: move the centre to the origin
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_valid <= 1'b0;
         off_x     <= '0;
         off_y     <= '0;
      end else begin
         off_valid <= pix_valid;
         off_x     <= DW'(pix_x) - DW'(ctr_x);
         off_y     <= DW'(pix_y) - DW'(ctr_y);
      end
   end

   assign ext_x = SW'(off_x);
   assign ext_y = SW'(off_y);
   assign acc_x = ext_x * SW'(COS_Q) + ext_y * SW'(SIN_Q);
   assign acc_y = ext_y * SW'(COS_Q) - ext_x * SW'(SIN_Q);

   // stage 2: rotate, floor to integer radius units
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rot_valid <= 1'b0;
         rot_x     <= '0;
         rot_y     <= '0;
      end else begin
         rot_valid <= off_valid;
         rot_x     <= RW'(acc_x >>> FRAC);
         rot_y     <= RW'(acc_y >>> FRAC);
      end
   end

   p_rot_latency_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> ##1 rot_valid);
   p_rot_idle_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> ##1 !rot_valid);
endmodule

// File: rtl/hcv_octant_fold.sv
module hcv_octant_fold
   import hcv_pkg::*;
#(
   parameter int RW       = 14,
   parameter int AW       = 6,
   parameter int DEPTH_AX = 32,
   parameter int DEPTH_DG = 46,
   localparam int VW      = RW + 2
) (
   input  logic signed [RW-1:0]     ra,
   input  logic signed [RW-1:0]     rc,
   output logic [NOCT-1:0][AW-1:0]  vaddr,
   output logic [NOCT-1:0]          vok
);
   logic signed [VW-1:0] val [NOCT];

   always_comb begin
      val[OCT_A] = VW'(ra);
      val[OCT_B] = VW'(ra) + VW'(rc);
      val[OCT_C] = VW'(rc);
      val[OCT_D] = VW'(ra) - VW'(rc);
   end

   generate
      for (genvar k = 0; k < NOCT; k++) begin : g_oct
         localparam int LIM = is_diag(k) ? DEPTH_DG : DEPTH_AX;
         if (k >= NOCT / 2) begin : g_neg
            assign val[k] = -val[k - NOCT / 2];
         end
         assign vok[k]   = !val[k][VW-1] && (val[k] < VW'(LIM));
         assign vaddr[k] = val[k][AW-1:0];
      end
   endgenerate
endmodule

// File: rtl/hcv_clear_seq.sv
module hcv_clear_seq #(
   parameter int DEPTH = 46,
   parameter int AW    = 6,
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   output logic          busy,
   output logic [AW-1:0] sweep_addr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy       <= 1'b1;
         sweep_addr <= '0;
      end else if (clr) begin
         busy       <= 1'b1;
         sweep_addr <= '0;
      end else if (busy) begin
         if (sweep_addr == LAST) begin
            busy <= 1'b0;
         end else begin
            sweep_addr <= sweep_addr + 1'b1;
         end
      end
   end

   p_sweep_end_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(sweep_addr) == LAST);
endmodule

// File: rtl/hcv_vote_bank.sv
module hcv_vote_bank #(
   parameter int DEPTH = 32,
   parameter int CW    = 8,
   parameter int AW    = 6,
   localparam int BW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam logic [CW-1:0] MAXC = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_en,
   input  logic [AW-1:0] clr_addr,
   input  logic          vote_en,
   input  logic [AW-1:0] vote_addr,
   input  logic [AW-1:0] rd_addr,
   output logic [CW-1:0] rd_cnt
);
   logic [CW-1:0] mem [DEPTH];
   logic          clr_in, vote_in, rd_in;

   assign clr_in  = clr_addr  < AW'(DEPTH);
   assign vote_in = vote_addr < AW'(DEPTH);
   assign rd_in   = rd_addr   < AW'(DEPTH);

   always_ff @(posedge clk) begin
      if (clr_en) begin
         if (clr_in) mem[clr_addr[BW-1:0]] <= '0;
      end else if (vote_en && vote_in) begin
         if (mem[vote_addr[BW-1:0]] != MAXC)
            mem[vote_addr[BW-1:0]] <= mem[vote_addr[BW-1:0]] + 1'b1;
      end
   end

   assign rd_cnt = rd_in ? mem[rd_addr[BW-1:0]] : '0;

   p_sat_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (vote_en && vote_in && !clr_en && mem[vote_addr[BW-1:0]] == MAXC)
      |=> mem[$past(vote_addr[BW-1:0])] == MAXC);
   p_no_vote_busy_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !(clr_en && vote_en));
endmodule

// File: rtl/hcv_circle_voter.sv
module hcv_circle_voter
   import hcv_pkg::*;
#(
   parameter int PIX_W    = 10,
   parameter int COEF_W   = 14,
   parameter int FRAC     = 12,
   parameter int COS_Q    = 3784,
   parameter int SIN_Q    = 1567,
   parameter int DEPTH_AX = 32,
   parameter int CNT_W    = 8,
   localparam int RW       = PIX_W + COEF_W + 2 - FRAC,
   localparam int DEPTH_DG = diag_depth(DEPTH_AX),
   localparam int AW       = $clog2(DEPTH_DG)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic signed [PIX_W-1:0] ctr_x,
   input  logic signed [PIX_W-1:0] ctr_y,
   input  logic                    pix_valid,
   input  logic signed [PIX_W-1:0] pix_x,
   input  logic signed [PIX_W-1:0] pix_y,
   output logic                    rot_valid,
   output logic signed [RW-1:0]    rot_x,
   output logic signed [RW-1:0]    rot_y,
   output logic                    busy,
   input  logic [CNT_W-1:0]        thr,
   input  logic [2:0]              rd_bank,
   input  logic [AW-1:0]           rd_addr,
   output logic [CNT_W-1:0]        rd_count,
   output logic                    rd_hit
);
   // elaboration checks
   if (DEPTH_AX < 2)         begin : g_bad_depth $error("DEPTH_AX must be at least 2"); end
   if (FRAC >= COEF_W)       begin : g_bad_frac  $error("FRAC must be below COEF_W"); end
   if (RW + 2 <= AW)         begin : g_bad_rw    $error("radius width too narrow for banks"); end
   if (CNT_W < 1)            begin : g_bad_cnt   $error("CNT_W must be positive"); end

   logic [NOCT-1:0][AW-1:0] vaddr;
   logic [NOCT-1:0]         vok;
   logic [AW-1:0]           sweep_addr;
   logic [CNT_W-1:0]        rd_cnt [NOCT];

   hcv_offset_rotor #(
      .PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC(FRAC), .COS_Q(COS_Q), .SIN_Q(SIN_Q)
   ) u_rotor (
      .clk(clk), .rst_n(rst_n), .ctr_x(ctr_x), .ctr_y(ctr_y),
      .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
      .rot_valid(rot_valid), .rot_x(rot_x), .rot_y(rot_y)
   );

   hcv_octant_fold #(
      .RW(RW), .AW(AW), .DEPTH_AX(DEPTH_AX), .DEPTH_DG(DEPTH_DG)
   ) u_fold (
      .ra(rot_x), .rc(rot_y), .vaddr(vaddr), .vok(vok)
   );

   hcv_clear_seq #(.DEPTH(DEPTH_DG), .AW(AW)) u_clear (
      .clk(clk), .rst_n(rst_n), .clr(clr), .busy(busy), .sweep_addr(sweep_addr)
   );

   generate
      for (genvar k = 0; k < NOCT; k++) begin : g_bank
         localparam int D = is_diag(k) ? DEPTH_DG : DEPTH_AX;
         hcv_vote_bank #(.DEPTH(D), .CW(CNT_W), .AW(AW)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .clr_en(busy), .clr_addr(sweep_addr),
            .vote_en(rot_valid && !busy && vok[k]), .vote_addr(vaddr[k]),
            .rd_addr(rd_addr), .rd_cnt(rd_cnt[k])
         );
      end
   endgenerate

   assign rd_count = rd_cnt[rd_bank];
   assign rd_hit   = rd_count >= thr;

   // opposite octants share a magnitude: both vote only at radius zero
   p_zero_pair_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (rot_valid && vok[OCT_A] && vok[OCT_E]) |-> rot_x == '0);
   p_diag_pair_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (rot_valid && vok[OCT_B] && vok[OCT_F]) |-> vaddr[OCT_B] == '0);
endmodule

// File: tb/hcv_circle_voter_tb.sv
module hcv_circle_voter_tb;
   localparam int CLK_PERIOD = 10;
   localparam int PW   = 10;
   localparam int CQ   = 3784;
   localparam int SQ   = 1567;
   localparam int FR   = 12;
   localparam int DAX  = 32;
   localparam int DDG  = 46;
   localparam int CMAX = 255;
   localparam int RW   = 14;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr = 1'b0;
   logic signed [PW-1:0] ctr_x = '0, ctr_y = '0, pix_x = '0, pix_y = '0;
   logic pix_valid = 1'b0;
   logic rot_valid, busy, rd_hit;
   logic signed [RW-1:0] rot_x, rot_y;
   logic [7:0] thr = '0;
   logic [2:0] rd_bank = '0;
   logic [5:0] rd_addr = '0;
   logic [7:0] rd_count;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int model [8][DDG];

   always #(CLK_PERIOD/2) clk = ~clk;

   hcv_circle_voter u_dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .ctr_x(ctr_x), .ctr_y(ctr_y),
      .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
      .rot_valid(rot_valid), .rot_x(rot_x), .rot_y(rot_y), .busy(busy),
      .thr(thr), .rd_bank(rd_bank), .rd_addr(rd_addr),
      .rd_count(rd_count), .rd_hit(rd_hit)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int depth_of(input int b);
      return (b % 2 == 1) ? DDG : DAX;
   endfunction

   function automatic int rot_a(input int x, input int y);
      longint s = longint'(x - int'(ctr_x)) * CQ + longint'(y - int'(ctr_y)) * SQ;
      return int'(s >>> FR);
   endfunction

   function automatic int rot_c(input int x, input int y);
      longint s = longint'(y - int'(ctr_y)) * CQ - longint'(x - int'(ctr_x)) * SQ;
      return int'(s >>> FR);
   endfunction

   task automatic model_vote(input int x, input int y);
      int ra = rot_a(x, y);
      int rc = rot_c(x, y);
      int v [8];
      v[0] = ra; v[1] = ra + rc; v[2] = rc; v[3] = ra - rc;
      for (int k = 0; k < 4; k++) v[k+4] = -v[k];
      for (int k = 0; k < 8; k++)
         if (v[k] >= 0 && v[k] < depth_of(k) && model[k][v[k]] < CMAX)
            model[k][v[k]]++;
   endtask

   task automatic model_clear();
      for (int b = 0; b < 8; b++)
         for (int a = 0; a < DDG; a++) model[b][a] = 0;
   endtask

   task automatic send(input int x, input int y, input bit count_it);
      @(negedge clk);
      pix_valid = 1'b1;
      pix_x = PW'(x);
      pix_y = PW'(y);
      if (count_it) model_vote(x, y);
   endtask

   task automatic drain();
      @(negedge clk);
      pix_valid = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   // R4 R5 R9: compare every cell, including reads past an axis bank's depth
   task automatic check_banks(input string req);
      for (int b = 0; b < 8; b++)
         for (int a = 0; a < DDG; a++) begin
            rd_bank = 3'(b);
            rd_addr = 6'(a);
            #1;
            check(req, int'(rd_count), (a < depth_of(b)) ? model[b][a] : 0);
         end
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int cnt;
      int ex, ey;
      void'($urandom(32'd1234));
      model_clear();
      ctr_x = PW'(100);
      ctr_y = PW'(-50);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R7: reset starts a sweep
      check("R7 busy after reset", int'(busy), 1);
      check("R2 rot_valid idle", int'(rot_valid), 0);
      wait_idle();
      check_banks("R7 cleared after reset");

      // R1 R2: single pixel, rotated pair two cycles later
      @(negedge clk);
      pix_valid = 1'b1; pix_x = PW'(103); pix_y = PW'(-46);
      model_vote(103, -46);
      @(negedge clk);
      pix_valid = 1'b0;
      check("R2 rot_valid early", int'(rot_valid), 0);
      @(negedge clk);
      check("R2 rot_valid", int'(rot_valid), 1);
      check("R1 R2 rot_x", int'(rot_x), rot_a(103, -46));
      check("R1 R2 rot_y", int'(rot_y), rot_c(103, -46));
      @(negedge clk);
      check("R2 rot_valid drop", int'(rot_valid), 0);
      repeat (2) @(negedge clk);
      check_banks("R3 R5 single pixel");

      // R2: negative offsets
      @(negedge clk);
      pix_valid = 1'b1; pix_x = PW'(80); pix_y = PW'(-60);
      model_vote(80, -60);
      @(negedge clk);
      pix_valid = 1'b0;
      @(negedge clk);
      check("R1 R2 rot_x neg", int'(rot_x), rot_a(80, -60));
      check("R1 R2 rot_y neg", int'(rot_y), rot_c(80, -60));
      repeat (3) @(negedge clk);

      // R4 R5: random burst around the centre, some beyond bank depth
      for (int i = 0; i < 300; i++) begin
         ex = 100 + $urandom_range(90, 0) - 45;
         ey = -50 + $urandom_range(90, 0) - 45;
         send(ex, ey, 1'b1);
      end
      drain();
      check_banks("R4 R5 random burst");

      // R9: threshold compare on a known cell
      rd_bank = 3'(0); rd_addr = 6'(0); #1;
      cnt = int'(rd_count);
      thr = 8'(cnt); #1;
      check("R9 hit at equal", int'(rd_hit), 1);
      thr = 8'(cnt + 1); #1;
      check("R9 miss above", int'(rd_hit), 0);

      // R7 R8: clear strobe, then a pixel during the sweep
      @(negedge clk);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      pix_valid = 1'b1; pix_x = PW'(100); pix_y = PW'(-50);
      @(negedge clk);
      pix_valid = 1'b0;
      cnt = 2;
      while (busy) begin
         @(negedge clk);
         if (busy) cnt++;
      end
      check("R7 sweep length", cnt, DDG);
      model_clear();
      check_banks("R7 R8 cleared, busy vote dropped");

      // R8: a vote landing in the first busy cycle after a clear is discarded
      @(negedge clk);
      pix_valid = 1'b1; pix_x = PW'(100); pix_y = PW'(-50);
      @(negedge clk);
      pix_valid = 1'b0;
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      wait_idle();
      rd_bank = 3'(4); rd_addr = 6'(0); #1;
      check("R8 vote during busy dropped", int'(rd_count), 0);

      // R6: centre pixel hits address 0 of every bank; saturate
      for (int i = 0; i < 300; i++) send(100, -50, 1'b1);
      drain();
      for (int b = 0; b < 8; b++) begin
         rd_bank = 3'(b); rd_addr = 6'(0); #1;
         check("R6 saturated count", int'(rd_count), CMAX);
      end
      thr = 8'(255); #1;
      check("R9 hit at max", int'(rd_hit), 1);

      // R9: reads past an axis bank's depth return zero
      rd_bank = 3'(2); rd_addr = 6'(40); #1;
      check("R9 out of range read", int'(rd_count), 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule